// File: doc/BRIEF.md
# Three-Port Parallel I/O with Handshake

This block gives a host three byte-wide parallel ports, called A, B and C, behind a small register interface with a 2-bit address. The host writes a configuration byte to the control address. That byte picks a mode for each port group. In simple mode the ports act as plain latched outputs or direct inputs. In strobed mode a port moves one byte at a time under a request/acknowledge handshake with an external device. In bidirectional mode port A carries data both ways. Pad tristating is modelled as separate in, out and output-enable vectors.

In the strobed and bidirectional modes, some pins of port C stop being plain I/O. They become handshake lines: an active-low strobe and an input-full flag for strobed input, and an active-low acknowledge and an output-full flag for strobed output. A write to the control address with bit 7 clear sets or clears one bit of the port C latch. That lets software toggle one control line without touching its neighbours.

The addresses are 0 for port A, 1 for port B, 2 for port C and 3 for control. A read of address 3 returns zero. A host read of a port has an effect only on the cycle in which the read strobe is high.

Top module: `par3_port`

## Requirements
- R1: After reset every bit of `pa_oe`, `pb_oe` and `pc_oe` is 0. All output latches are 0.
- R2: A control write with bit 7 set defines the modes.
  - Bits 6:5 give the port A mode: 00 simple, 01 strobed, 1x bidirectional.
  - Bit 4 gives the port A direction, bit 3 the port C bits 7:4 direction, bit 1 the port B direction and bit 0 the port C bits 3:0 direction. In each case 1 means input.
  - Bit 2 set makes port B strobed.
  - In simple mode an output port drives its latch on all pins. An input port drives nothing, and a read of it returns its pins.
- R3: A mode-defining control write clears the port A, B and C output latches to zero. It also clears both input-full flags, and it returns both output-full lines high (empty).
- R4: A control write with bit 7 clear writes bit 0 into the port C latch bit selected by bits 3:1. All other latch bits keep their values.
- R5: Strobed input works as follows.
  - For port A the strobe is PC4 and the full flag is PC5. For port B they are PC2 and PC1.
  - In every cycle the strobe is low, the port pins are captured and the flag is set to 1.
  - A read of the port returns the captured byte, not the live pins.
  - A read of the port clears the flag.
- R6: When the strobe is low in the same cycle as a host read of that port, the input-full flag stays set. The newly captured byte is then returned by the next read.
- R7: Strobed output works as follows.
  - For port A the acknowledge is PC6 and the output-full line is PC7, active low. For port B they are PC2 and PC1.
  - A host write to the port drives the output-full line low.
  - A cycle with the acknowledge low returns it high.
  - A strobed output port drives all its pins.
- R8: When a host write to a strobed output port falls in the same cycle as a low acknowledge, the output-full line ends low.
- R9: In bidirectional mode port A drives all its pins only while PC6 is low, and drives none at other times. PC4 and PC5 serve as the input handshake and PC7 as the output-full line.
- R10: Port C pins used as handshake inputs are never driven. Port C pins used as flag outputs are driven with their flag. A read of port C returns the flags on those flag bits and the pins on the handshake-input bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 2 | Host register select: 0 port A, 1 port B, 2 port C, 3 control |
| wr_en | input | 1 | Host write strobe for this cycle |
| rd_en | input | 1 | Host read strobe for this cycle |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Host read data (combinational from addr) |
| pa_in | input | 8 | Port A pin input |
| pa_out | output | 8 | Port A pin output value |
| pa_oe | output | 8 | Port A pin output enable |
| pb_in | input | 8 | Port B pin input |
| pb_out | output | 8 | Port B pin output value |
| pb_oe | output | 8 | Port B pin output enable |
| pc_in | input | 8 | Port C pin input (also handshake inputs) |
| pc_out | output | 8 | Port C pin output value (also handshake flags) |
| pc_oe | output | 8 | Port C pin output enable |

## Verification
Two pairs of events can fall in the same cycle.
- For an input-full flag, a device strobe that sets the flag can meet a host read that clears it. The bench holds PC4 low in the very cycle that `rd_en` addresses port A. It then expects PC5 still high, and expects the following read to return the byte captured under that strobe.
- For an output-full line, a host write to port B can land in the cycle in which PC2 is held low as the acknowledge. The bench then expects PC1 low afterwards, and a later lone acknowledge to raise it again.

// File: rtl/par3_pkg.sv
package par3_pkg;

    localparam int PW = 8;
    localparam int AW = 2;
    localparam int SELW = $clog2(PW);

    localparam logic [AW-1:0] ADR_A   = 2'd0;
    localparam logic [AW-1:0] ADR_B   = 2'd1;
    localparam logic [AW-1:0] ADR_C   = 2'd2;
    localparam logic [AW-1:0] ADR_CTL = 2'd3;

    // handshake bit positions within port C
    localparam int PC_OBFA = 7;
    localparam int PC_ACKA = 6;
    localparam int PC_IBFA = 5;
    localparam int PC_STBA = 4;
    localparam int PC_HSBI = 2;
    localparam int PC_HSBO = 1;
    localparam int PC_SPLIT = 4;

    typedef enum logic [1:0] {
        AM_SIMPLE = 2'd0,
        AM_STROBE = 2'd1,
        AM_BIDIR  = 2'd2
    } amode_e;

    typedef enum logic [1:0] {
        PCR_IO    = 2'd0,
        PCR_HSIN  = 2'd1,
        PCR_HSOUT = 2'd2
    } pcrole_e;

    typedef struct packed {
        amode_e a_mode;
        logic   a_in;
        logic   cu_in;
        logic   b_strobe;
        logic   b_in;
        logic   cl_in;
    } cfg_t;

    localparam cfg_t CFG_RESET = '{a_mode: AM_SIMPLE, a_in: 1'b1, cu_in: 1'b1,
                                   b_strobe: 1'b0, b_in: 1'b1, cl_in: 1'b1};

    function automatic cfg_t decode_cfg(input logic [7:0] w);
        cfg_t c;
        c.a_mode   = w[6] ? AM_BIDIR : (w[5] ? AM_STROBE : AM_SIMPLE);
        c.a_in     = w[4];
        c.cu_in    = w[3];
        c.b_strobe = w[2];
        c.b_in     = w[1];
        c.cl_in    = w[0];
        return c;
    endfunction

    function automatic pcrole_e pc_role(input int idx, input logic ai, input logic ao,
                                        input logic bs);
        pcrole_e r;
        r = PCR_IO;
        case (idx)
            PC_OBFA: if (ao) r = PCR_HSOUT;
            PC_ACKA: if (ao) r = PCR_HSIN;
            PC_IBFA: if (ai) r = PCR_HSOUT;
            PC_STBA: if (ai) r = PCR_HSIN;
            PC_HSBI: if (bs) r = PCR_HSIN;
            PC_HSBO: if (bs) r = PCR_HSOUT;
            default: r = PCR_IO;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/par3_ctrl.sv
module par3_ctrl
    import par3_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [PW-1:0] wdata,
    output cfg_t          cfg,
    output logic [PW-1:0] pc_lat,
    output logic          def_wr
);

    logic bsr_wr;
    logic pcw;

    always_comb begin
        def_wr = wr_en && (addr == ADR_CTL) && wdata[7];
        bsr_wr = wr_en && (addr == ADR_CTL) && !wdata[7];
        pcw    = wr_en && (addr == ADR_C);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg    <= CFG_RESET;
            pc_lat <= '0;
        end else if (def_wr) begin
            cfg    <= decode_cfg(wdata);
            pc_lat <= '0;
        end else if (bsr_wr) begin
            pc_lat[wdata[SELW:1]] <= wdata[0];
        end else if (pcw) begin
            pc_lat <= wdata;
        end
    end

    // R3
    def_clears_pc_chk: assert property (@(posedge clk) disable iff (rst)
        def_wr |=> (pc_lat == '0));

    // R4
    bsr_sets_bit_chk: assert property (@(posedge clk) disable iff (rst)
        bsr_wr |=> (pc_lat[$past(wdata[SELW:1])] == $past(wdata[0])));

    // R4
    bsr_keeps_rest_chk: assert property (@(posedge clk) disable iff (rst)
        bsr_wr |=> (((pc_lat ^ $past(pc_lat)) & ~(8'h01 << $past(wdata[SELW:1]))) == '0));

endmodule

// File: rtl/par3_chan.sv
module par3_chan
    import par3_pkg::*;
#(
    parameter int W = PW
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         in_mode,
    input  logic         out_mode,
    input  logic         stb_n,
    input  logic         ack_n,
    input  logic [W-1:0] pin_data,
    input  logic         host_wr,
    input  logic         host_rd,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] in_buf,
    output logic         ibf,
    output logic [W-1:0] out_lat,
    output logic         obf_n
);

    always_ff @(posedge clk) begin
        if (rst) begin
            in_buf <= '0;
        end else if (in_mode && !stb_n) begin
            in_buf <= pin_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            ibf <= 1'b0;
        end else if (in_mode && !stb_n) begin
            ibf <= 1'b1;
        end else if (in_mode && host_rd) begin
            ibf <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            out_lat <= '0;
        end else if (host_wr) begin
            out_lat <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            obf_n <= 1'b1;
        end else if (out_mode && host_wr) begin
            obf_n <= 1'b0;
        end else if (out_mode && !ack_n) begin
            obf_n <= 1'b1;
        end
    end

    // R5
    ibf_set_chk: assert property (@(posedge clk) disable iff (rst)
        (in_mode && !stb_n && !clr) |=> ibf);

    // R5
    ibf_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (in_mode && stb_n && host_rd && !clr) |=> !ibf);

    // R7
    obf_write_chk: assert property (@(posedge clk) disable iff (rst)
        (out_mode && host_wr && !clr) |=> !obf_n);

    // R7
    obf_ack_chk: assert property (@(posedge clk) disable iff (rst)
        (out_mode && !host_wr && !ack_n && !clr) |=> obf_n);

endmodule

// File: rtl/par3_port.sv
module par3_port
    import par3_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] addr,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [PW-1:0] wdata,
    output logic [PW-1:0] rdata,
    input  logic [PW-1:0] pa_in,
    output logic [PW-1:0] pa_out,
    output logic [PW-1:0] pa_oe,
    input  logic [PW-1:0] pb_in,
    output logic [PW-1:0] pb_out,
    output logic [PW-1:0] pb_oe,
    input  logic [PW-1:0] pc_in,
    output logic [PW-1:0] pc_out,
    output logic [PW-1:0] pc_oe
);

    localparam int NCH = 2;

    cfg_t          cfg;
    logic [PW-1:0] pc_lat;
    logic          def_wr;

    par3_ctrl i_ctrl (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .addr   (addr),
        .wdata  (wdata),
        .cfg    (cfg),
        .pc_lat (pc_lat),
        .def_wr (def_wr)
    );

    logic a_sin, a_sout, b_sin, b_sout;

    always_comb begin
        a_sin  = ((cfg.a_mode == AM_STROBE) && cfg.a_in) || (cfg.a_mode == AM_BIDIR);
        a_sout = ((cfg.a_mode == AM_STROBE) && !cfg.a_in) || (cfg.a_mode == AM_BIDIR);
        b_sin  = cfg.b_strobe && cfg.b_in;
        b_sout = cfg.b_strobe && !cfg.b_in;
    end

    logic [NCH-1:0] ch_in_mode, ch_out_mode, ch_stb_n, ch_ack_n;
    logic [NCH-1:0] ch_wr, ch_rd, ch_ibf, ch_obf_n;
    logic [PW-1:0]  ch_pin  [NCH];
    logic [PW-1:0]  ch_ibuf [NCH];
    logic [PW-1:0]  ch_olat [NCH];

    always_comb begin
        ch_in_mode  = {b_sin, a_sin};
        ch_out_mode = {b_sout, a_sout};
        ch_stb_n    = {pc_in[PC_HSBI], pc_in[PC_STBA]};
        ch_ack_n    = {pc_in[PC_HSBI], pc_in[PC_ACKA]};
        ch_wr       = {wr_en && (addr == ADR_B), wr_en && (addr == ADR_A)};
        ch_rd       = {rd_en && (addr == ADR_B), rd_en && (addr == ADR_A)};
        ch_pin[0]   = pa_in;
        ch_pin[1]   = pb_in;
    end

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        par3_chan #(.W(PW)) i_chan (
            .clk      (clk),
            .rst      (rst),
            .clr      (def_wr),
            .in_mode  (ch_in_mode[g]),
            .out_mode (ch_out_mode[g]),
            .stb_n    (ch_stb_n[g]),
            .ack_n    (ch_ack_n[g]),
            .pin_data (ch_pin[g]),
            .host_wr  (ch_wr[g]),
            .host_rd  (ch_rd[g]),
            .wdata    (wdata),
            .in_buf   (ch_ibuf[g]),
            .ibf      (ch_ibf[g]),
            .out_lat  (ch_olat[g]),
            .obf_n    (ch_obf_n[g])
        );
    end

    // port A and B pins
    always_comb begin
        pa_out = ch_olat[0];
        pb_out = ch_olat[1];
        if (cfg.a_mode == AM_BIDIR) begin
            pa_oe = {PW{!pc_in[PC_ACKA]}};
        end else begin
            pa_oe = {PW{!cfg.a_in}};
        end
        pb_oe = {PW{!cfg.b_in}};
    end

    // port C handshake flag values
    logic [PW-1:0] pc_stat;

    always_comb begin
        pc_stat          = '0;
        pc_stat[PC_OBFA] = ch_obf_n[0];
        pc_stat[PC_IBFA] = ch_ibf[0];
        pc_stat[PC_HSBO] = b_sin ? ch_ibf[1] : ch_obf_n[1];
    end

    logic [PW-1:0] pc_rd;

    for (genvar g = 0; g < PW; g++) begin : g_pcbit
        pcrole_e role;
        logic    grp_in;
        assign role   = pc_role(g, a_sin, a_sout, cfg.b_strobe);
        assign grp_in = (g >= PC_SPLIT) ? cfg.cu_in : cfg.cl_in;
        assign pc_oe[g]  = (role == PCR_HSOUT) || ((role == PCR_IO) && !grp_in);
        assign pc_out[g] = (role == PCR_HSOUT) ? pc_stat[g] : pc_lat[g];
        assign pc_rd[g]  = (role == PCR_HSOUT) ? pc_stat[g] :
                           (((role == PCR_HSIN) || grp_in) ? pc_in[g] : pc_lat[g]);
    end

    // host read mux
    always_comb begin
        case (addr)
            ADR_A:   rdata = a_sin ? ch_ibuf[0] : (cfg.a_in ? pa_in : ch_olat[0]);
            ADR_B:   rdata = b_sin ? ch_ibuf[1] : (cfg.b_in ? pb_in : ch_olat[1]);
            ADR_C:   rdata = pc_rd;
            default: rdata = '0;
        endcase
    end

    // R9
    bidir_float_chk: assert property (@(posedge clk) disable iff (rst)
        ((cfg.a_mode == AM_BIDIR) && pc_in[PC_ACKA]) |-> (pa_oe == '0));

    // R10
    stb_undriven_chk: assert property (@(posedge clk) disable iff (rst)
        (a_sin || cfg.b_strobe) |-> !((a_sin && pc_oe[PC_STBA]) ||
                                      (cfg.b_strobe && pc_oe[PC_HSBI])));

    // R2
    simple_in_float_chk: assert property (@(posedge clk) disable iff (rst)
        cfg.b_in |-> (pb_oe == '0));

endmodule

// File: tb/test_par3_port.sv
module test_par3_port;
    import par3_pkg::*;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] addr = '0;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic [PW-1:0] wdata = '0;
    logic [PW-1:0] rdata;
    logic [PW-1:0] pa_in = '0;
    logic [PW-1:0] pa_out, pa_oe;
    logic [PW-1:0] pb_in = '0;
    logic [PW-1:0] pb_out, pb_oe;
    logic [PW-1:0] pc_in = 8'hFF;
    logic [PW-1:0] pc_out, pc_oe;

    par3_port i_par3_port (
        .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata),
        .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
        .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
        .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe)
    );

    always #2 clk = ~clk;

    localparam int S_RD = 0, S_PAO = 1, S_PAE = 2, S_PBO = 3, S_PBE = 4, S_PCO = 5, S_PCE = 6;

    string      q_req [$];
    int         q_sel [$];
    logic [7:0] q_exp [$];

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    string      m_req;
    int         m_sel;
    logic [7:0] m_exp, m_act;

    // monitor: compare queued expectations mid-cycle
    always @(negedge clk) begin
        while (q_sel.size() > 0) begin
            m_req = q_req.pop_front();
            m_sel = q_sel.pop_front();
            m_exp = q_exp.pop_front();
            case (m_sel)
                S_RD:    m_act = rdata;
                S_PAO:   m_act = pa_out;
                S_PAE:   m_act = pa_oe;
                S_PBO:   m_act = pb_out;
                S_PBE:   m_act = pb_oe;
                S_PCO:   m_act = pc_out;
                default: m_act = pc_oe;
            endcase
            n_tests++;
            if (m_act !== m_exp) begin
                n_fail++;
                $display("FAIL %s sel=%0d actual=%02h expected=%02h", m_req, m_sel, m_act, m_exp);
            end
        end
    end

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic push(input string req, input int sel, input logic [7:0] val);
        q_req.push_back(req);
        q_sel.push_back(sel);
        q_exp.push_back(val);
    endtask

    task automatic settle();
        wait (q_sel.size() == 0);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        cyc();
        wr_en = 1'b0;
    endtask

    task automatic rd_exp(input string req, input logic [1:0] a, input logic [7:0] val);
        addr = a; rd_en = 1'b1;
        push(req, S_RD, val);
        settle();
        cyc();
        rd_en = 1'b0;
    endtask

    task automatic pulse_c(input logic [7:0] v);
        pc_in = v;
        cyc();
        pc_in = 8'hFF;
    endtask

    initial begin
        #(4 * 100000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) cyc();
        rst = 1'b0;
        cyc();
        // R1 reset state
        push("R1 pa_oe", S_PAE, 8'h00);
        push("R1 pb_oe", S_PBE, 8'h00);
        push("R1 pc_oe", S_PCE, 8'h00);
        push("R1 pa_out", S_PAO, 8'h00);
        settle();

        // R2 simple mode: A out, C out, B in
        wr(ADR_CTL, 8'h82);
        wr(ADR_A, 8'hA5);
        push("R2 pa_out", S_PAO, 8'hA5);
        push("R2 pa_oe", S_PAE, 8'hFF);
        push("R2 pb_oe", S_PBE, 8'h00);
        settle();
        pb_in = 8'h3C;
        rd_exp("R2 pb read pins", ADR_B, 8'h3C);
        wr(ADR_C, 8'h5A);
        push("R2 pc_out", S_PCO, 8'h5A);
        push("R2 pc_oe", S_PCE, 8'hFF);
        settle();

        // R3 mode write clears latches
        wr(ADR_CTL, 8'h82);
        push("R3 pa_out", S_PAO, 8'h00);
        push("R3 pc_out", S_PCO, 8'h00);
        settle();

        // R4 bit set/reset
        wr(ADR_C, 8'hF0);
        wr(ADR_CTL, 8'h07);
        push("R4 set bit3", S_PCO, 8'hF8);
        settle();
        wr(ADR_CTL, 8'h0C);
        push("R4 clear bit6", S_PCO, 8'hB8);
        settle();
        rd_exp("R4 pc read", ADR_C, 8'hB8);

        // R5 port A strobed input
        wr(ADR_CTL, 8'hB0);
        push("R10 pc_oe strobed A in", S_PCE, 8'hEF);
        push("R5 ibf idle", S_PCO, 8'h00);
        push("R5 pa_oe", S_PAE, 8'h00);
        settle();
        pa_in = 8'h77;
        pulse_c(8'hEF);
        pa_in = 8'h11;
        push("R5 ibf set", S_PCO, 8'h20);
        settle();
        rd_exp("R5 latched data", ADR_A, 8'h77);
        push("R5 ibf cleared", S_PCO, 8'h00);
        settle();
        rd_exp("R10 pc read stb pin", ADR_C, 8'h10);

        // R6 strobe and read together
        pa_in = 8'h22;
        pc_in = 8'hEF; addr = ADR_A; rd_en = 1'b1;
        cyc();
        pc_in = 8'hFF; rd_en = 1'b0;
        push("R6 ibf held", S_PCO, 8'h20);
        settle();
        rd_exp("R6 new data", ADR_A, 8'h22);
        push("R6 ibf cleared", S_PCO, 8'h00);
        settle();

        // R7 port B strobed output
        wr(ADR_CTL, 8'h9D);
        push("R2 pa_oe input", S_PAE, 8'h00);
        push("R7 pb_oe", S_PBE, 8'hFF);
        push("R10 pc_oe strobed B out", S_PCE, 8'h02);
        push("R7 obf idle", S_PCO, 8'h02);
        settle();
        wr(ADR_B, 8'hC3);
        push("R7 pb_out", S_PBO, 8'hC3);
        push("R7 obf low", S_PCO, 8'h00);
        settle();
        pulse_c(8'hFB);
        push("R7 obf after ack", S_PCO, 8'h02);
        settle();

        // R8 write and ack together
        pc_in = 8'hFB; addr = ADR_B; wdata = 8'h3C; wr_en = 1'b1;
        cyc();
        pc_in = 8'hFF; wr_en = 1'b0;
        push("R8 obf low", S_PCO, 8'h00);
        push("R8 pb_out", S_PBO, 8'h3C);
        settle();
        pulse_c(8'hFB);
        push("R8 obf later ack", S_PCO, 8'h02);
        settle();

        // R9 bidirectional port A
        wr(ADR_CTL, 8'hC3);
        push("R3 pb_out cleared", S_PBO, 8'h00);
        push("R9 pc_oe", S_PCE, 8'hA0);
        push("R9 flags idle", S_PCO, 8'h80);
        push("R9 pa float", S_PAE, 8'h00);
        settle();
        wr(ADR_A, 8'h99);
        push("R9 obf low", S_PCO, 8'h00);
        push("R9 pa float no ack", S_PAE, 8'h00);
        settle();
        pc_in = 8'hBF;
        push("R9 pa driven on ack", S_PAE, 8'hFF);
        push("R9 pa data", S_PAO, 8'h99);
        settle();
        cyc();
        pc_in = 8'hFF;
        push("R9 pa float after ack", S_PAE, 8'h00);
        push("R9 obf high", S_PCO, 8'h80);
        settle();
        pa_in = 8'h5E;
        pulse_c(8'hEF);
        push("R9 ibf set", S_PCO, 8'hA0);
        settle();
        rd_exp("R9 input data", ADR_A, 8'h5E);
        push("R9 ibf cleared", S_PCO, 8'h80);
        settle();

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule